// File: doc/BRIEF.md
# Digit-Serial Booth-Recoded Programmable FIR Filter

This block is a small programmable finite-impulse-response filter. Each input sample is taken whole, in parallel form, and kept in a short line of held samples. The coefficients are not stored inside the block. For every output they arrive two bits per tap per cycle, and each tap recodes them into radix-4 signed digits. A digit selects zero, plus or minus the held sample, or plus or minus twice the held sample, as one partial product. Each new coefficient set applies to the sample it comes with, so the filter response can change at run time.

All taps feed one shared carry-save accumulator through a chain of 3:2 compressors. Partial sums move from tap to tap as sum and carry vectors and are not resolved on the way. Each tap starts one cycle later than the tap before it. When the last digit of the last tap has been added, a single carry-propagate adder resolves the accumulator into the output word. The output is exact: it is as wide as the sum of all taps at full precision.

Top module: `fdb_fir`

## Requirements
- R1: While reset is held and right after it, `out_valid` is 0 and `out_data` is 0. The held-sample line and the accumulator start at zero.
- R2: A sample is accepted on a clock edge where `in_valid` is 1 and the block is idle. A `in_valid` pulse or a new `in_data` value while a computation is running has no effect on any output.
- R3: Bits [2k+1:2k] of `coef_pairs` carry the coefficient of tap k. The pairs come least significant first. Pair i of tap k is presented in step i+k, and step 0 is the cycle right after the accepting edge. The pair value is ignored in steps where tap k is inactive.
- R4: Each tap recodes its bits into digits from the triplet (b[2i+1], b[2i], b[2i-1]), with b[-1] = 0. The digit value is -2*b[2i+1] + b[2i] + b[2i-1].
- R5: `out_data` equals the sum over k of c_k * x[n-k], in two's complement. Here x[n] is the sample just accepted, c_k is the coefficient streamed with it, and tap 0 multiplies the newest sample.
- R6: `out_valid` is 1 for exactly one cycle, on the edge NDIG+TAPS cycles after the accepting edge. NDIG is CW/2.
- R7: `out_data` keeps its value until the next result is produced.
- R8: Coefficients may differ from one sample to the next, and each result uses only the coefficients streamed with its own sample.
- R9: With all samples and all coefficients at the most negative value, the result is exact and has no overflow (65536 with the default widths).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A new sample is offered |
| in_data | input | DW | Sample, two's complement |
| coef_pairs | input | 2*TAPS | One coefficient bit pair per tap, skewed per tap |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DW+CW+clog2(TAPS) | Filter output, two's complement |

## Verification
An impulse under a constant coefficient set gives each coefficient in turn. This separates the taps and shows that the samples shift in the right order. Mixed-sign samples and coefficients, including pair patterns that recode to -2 and +2, test the recoding of every triplet. The same sign cases also test the negation bit that is carried into the compressor chain. Runs with every value at its most negative test the width of the accumulator. A run where the coefficients change for every sample, with spurious strobes and different data sent during the computation, shows that each result depends only on its own coefficients and on the samples held when it started.

// File: rtl/fdb_pkg.sv
package fdb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } fdb_state_e;
endpackage

// File: rtl/fdb_ctrl.sv
module fdb_ctrl #(
  parameter int STEPS = 7,
  parameter int CNTW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            start,
  output logic            step_en,
  output logic [CNTW-1:0] cnt,
  output logic            out_en
);
  import fdb_pkg::*;

  localparam logic [CNTW-1:0] LAST = CNTW'(STEPS - 1);

  fdb_state_e      state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start   = 1'b0;
    step_en = 1'b0;
    out_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          start   = 1'b1;
          cnt_d   = '0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step_en = 1'b1;
        if (cnt_q == LAST) state_d = ST_DONE;
        else               cnt_d   = cnt_q + 1'b1;
      end
      ST_DONE: begin
        out_en  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R6: the result phase comes only right after the final step
  a_r6_done_after_last_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/fdb_tap.sv
module fdb_tap #(
  parameter int DW = 8,
  parameter int AW = 18,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          active,
  input  logic [1:0]    pair,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] x,
  input  logic [AW-1:0] s_in,
  input  logic [AW-1:0] c_in,
  output logic [AW-1:0] s_out,
  output logic [AW-1:0] c_out
);
  logic          prev_q, prev_d;
  logic          pos1, pos2, neg1, neg2;
  logic [AW-1:0] mag, mag_sh, pp;
  logic          neg;

  always_comb begin
    pos1 = 1'b0; pos2 = 1'b0; neg1 = 1'b0; neg2 = 1'b0;
    case ({pair, prev_q})
      3'b001, 3'b010: pos1 = 1'b1;
      3'b011:         pos2 = 1'b1;
      3'b100:         neg2 = 1'b1;
      3'b101, 3'b110: neg1 = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    mag = {{(AW-DW){x[DW-1]}}, x};
    if (pos2 || neg2) mag = mag << 1;
    if (!(pos1 || pos2 || neg1 || neg2)) mag = '0;
    mag_sh = mag << {idx, 1'b0};
    neg    = active && (neg1 || neg2);
    if (!active)  pp = '0;
    else if (neg) pp = ~mag_sh;
    else          pp = mag_sh;
    s_out = s_in ^ c_in ^ pp;
    c_out = {((s_in & c_in) | (s_in & pp) | (c_in & pp)), 1'b0} [AW-1:0] | {{(AW-1){1'b0}}, neg};
  end

  always_comb begin
    prev_d = prev_q;
    if (start)       prev_d = 1'b0;
    else if (active) prev_d = pair[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  // R4: a recoded digit never selects two partial products at once
  a_r4_one_booth_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pos1, pos2, neg1, neg2}));
endmodule

// File: rtl/fdb_fir.sv
module fdb_fir #(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int TAPS = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  input  logic [DW-1:0]                         in_data,
  input  logic [2*TAPS-1:0]                     coef_pairs,
  output logic                                  out_valid,
  output logic [DW+CW+$clog2(TAPS)-1:0]         out_data
);
  localparam int NDIG  = CW / 2;
  localparam int STEPS = NDIG + TAPS - 1;
  localparam int AW    = DW + CW + $clog2(TAPS);
  localparam int CNTW  = $clog2(STEPS + 1);
  localparam int IW    = (NDIG > 1) ? $clog2(NDIG) : 1;

  logic                       rst_meta, rst_sync;
  logic                       start, step_en, out_en;
  logic [CNTW-1:0]            cnt;
  logic [TAPS-1:0][DW-1:0]    x_q, x_d;
  logic [AW-1:0]              acc_s_q, acc_c_q, acc_s_d, acc_c_d;
  logic [AW-1:0]              s_ch [TAPS+1];
  logic [AW-1:0]              c_ch [TAPS+1];
  logic [AW-1:0]              res_d;
  logic                       ov_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  fdb_ctrl #(.STEPS(STEPS), .CNTW(CNTW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .in_valid(in_valid),
    .start(start), .step_en(step_en), .cnt(cnt), .out_en(out_en)
  );

  assign s_ch[0] = acc_s_q;
  assign c_ch[0] = acc_c_q;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam logic [CNTW:0] LO = (CNTW+1)'(k);
    localparam logic [CNTW:0] HI = (CNTW+1)'(k + NDIG);
    logic [CNTW:0] rel;
    logic          act;
    assign rel = {1'b0, cnt} - LO;
    assign act = step_en && ({1'b0, cnt} >= LO) && ({1'b0, cnt} < HI);
    fdb_tap #(.DW(DW), .AW(AW), .IW(IW)) u_tap (
      .clk(clk), .rst_n(rst_sync), .start(start), .active(act),
      .pair(coef_pairs[2*k +: 2]), .idx(rel[IW-1:0]), .x(x_q[k]),
      .s_in(s_ch[k]), .c_in(c_ch[k]), .s_out(s_ch[k+1]), .c_out(c_ch[k+1])
    );
  end

  always_comb begin
    x_d     = x_q;
    acc_s_d = acc_s_q;
    acc_c_d = acc_c_q;
    if (start) begin
      for (int k = TAPS - 1; k > 0; k--) x_d[k] = x_q[k-1];
      x_d[0]  = in_data;
      acc_s_d = '0;
      acc_c_d = '0;
    end else if (step_en) begin
      acc_s_d = s_ch[TAPS];
      acc_c_d = c_ch[TAPS];
    end
    res_d = out_en ? (acc_s_q + acc_c_q) : out_data;
    ov_d  = out_en;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      x_q       <= '0;
      acc_s_q   <= '0;
      acc_c_q   <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      x_q       <= x_d;
      acc_s_q   <= acc_s_d;
      acc_c_q   <= acc_c_d;
      out_data  <= res_d;
      out_valid <= ov_d;
    end
  end

  // R6: the result strobe lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_sync)
    out_valid |=> !out_valid);
  // R2: held samples stay put while digits are being accumulated
  a_r2_hold_samples: assert property (@(posedge clk) disable iff (!rst_sync)
    step_en |=> $stable(x_q));
  // R7: the output word changes only together with a strobe
  a_r7_output_held: assert property (@(posedge clk) disable iff (!rst_sync)
    !out_valid |-> $stable(out_data));
endmodule

// File: tb/fdb_fir_bench.sv
module fdb_fir_bench;
  localparam int DW = 8, CW = 8, TAPS = 4;
  localparam int AW = DW + CW + $clog2(TAPS);

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_valid;
  logic [DW-1:0]        in_data;
  logic [2*TAPS-1:0]    coef_pairs;
  logic                 out_valid;
  logic [AW-1:0]        out_data;

  int n_vec = 0;
  int n_bad = 0;
  int sb[$];
  int hist[TAPS];
  bit finished = 1'b0;

  always #10ns clk = ~clk;

  fdb_fir #(.DW(DW), .CW(CW), .TAPS(TAPS)) u_fdb_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .coef_pairs(coef_pairs), .out_valid(out_valid), .out_data(out_data)
  );

  // monitor: R5, R8, R9 result comparison
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      int exp_v;
      int got;
      got = int'($signed(out_data));
      n_vec++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R5 unexpected result actual=%0d expected=none", got);
      end else begin
        exp_v = sb.pop_front();
        if (got != exp_v) begin
          n_bad++;
          $display("FAIL R5 result actual=%0d expected=%0d", got, exp_v);
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp_v);
    n_vec++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // driver: pushes expected value, streams skewed bit pairs (R3, R4)
  task automatic drive(input logic signed [7:0] x, input logic [31:0] cf, input bit junk);
    int e = 0;
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = int'(x);
    for (int k = 0; k < TAPS; k++) e += int'($signed(cf[8*k +: 8])) * hist[k];
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b1; in_data = x; coef_pairs = '0;
    for (int j = 1; j <= 9; j++) begin
      @(negedge clk);
      check("R6 strobe timing", int'(out_valid), (j == 9) ? 1 : 0);
      in_valid = junk && (j <= 8);   // R2: strobes while busy are ignored
      in_data  = ~x;
      for (int k = 0; k < TAPS; k++) begin
        int i;
        i = (j - 1) - k;
        if (i >= 0 && i < CW / 2) coef_pairs[2*k +: 2] = cf[8*k + 2*i +: 2];
        else                      coef_pairs[2*k +: 2] = 2'b10;  // R3: ignored
      end
    end
    in_valid = 1'b0;
    coef_pairs = '0;
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held;
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; coef_pairs = '0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 out_data in reset", int'(out_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);

    // R5: impulse picks out each tap in order
    drive(8'sd1, {8'd4, 8'd3, 8'd2, 8'd1}, 1'b0);
    drive(8'sd0, {8'd4, 8'd3, 8'd2, 8'd1}, 1'b0);
    drive(8'sd0, {8'd4, 8'd3, 8'd2, 8'd1}, 1'b0);
    drive(8'sd0, {8'd4, 8'd3, 8'd2, 8'd1}, 1'b0);
    // R4: mixed signs, pairs recoding to +2 and -2
    drive(-8'sd5,  {8'hFD, 8'h07, 8'h80, 8'h7F}, 1'b0);
    drive(8'sd100, {8'h5A, 8'hA5, 8'h6B, 8'h94}, 1'b0);
    drive(-8'sd128, {8'hFD, 8'h07, 8'h80, 8'h7F}, 1'b0);
    drive(8'sd127, {8'h33, 8'hCC, 8'h96, 8'h69}, 1'b0);
    // R9: most negative everywhere
    for (int r = 0; r < 4; r++) drive(-8'sd128, 32'h80808080, 1'b0);
    // R8 and R2: new coefficients each sample, spurious strobes during work
    drive(8'sd55,  {8'h01, 8'hFF, 8'h02, 8'hFE}, 1'b1);
    drive(-8'sd77, {8'h7F, 8'h00, 8'h81, 8'h10}, 1'b1);
    drive(8'sd3,   {8'hC0, 8'h40, 8'h20, 8'hE0}, 1'b1);
    // R7: output held between results
    held = out_data;
    repeat (6) @(negedge clk);
    check("R7 out_data held", int'(out_data), int'(held));
    check("R2 no extra result", int'(out_valid), 0);
    check("R5 scoreboard drained", sb.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule